// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block sequences a 12-bit successive-approximation conversion on a charge-balancing capacitor array. All activity is tied to the rising clock edge. The block waits in a track-and-balance state until its active-low start input is sampled low. It then runs a fixed schedule of fifteen clock periods:

- three periods track the input while the comparator auto-balances;
- one period sets up the MSB trial;
- one period tests each remaining bit, MSB first.

A one-bit comparator result is sampled on each test edge. Its value decides whether the capacitor of the bit under test stays on the positive reference or drops back to the negative one.

When the last bit has been decided, all twelve result bits enter the output register together. The data-ready flag then rises. The result bus is split into an upper group (bits 11..4) and a lower group (bits 3..0). Each group has its own active-low output enable, and a disabled group floats. The analog array and the comparator are outside the block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the following hold on the next clock edge:
  - `ready` is 0 and the result register is 0;
  - `track` and `balance` are 1;
  - every capacitor field selects the input.
- R2: In the idle state, `track` and `balance` stay 1 and every field of `cap_sel` is 2'b00 (input) until `start_n` is sampled low.
- R3: Once `start_n` is sampled low in idle, the following three periods (periods 1..3) keep `track`=1, `balance`=1 and every field at 2'b00.
- R4: In period 4, `track` and `balance` are 0. Field 11 (`cap_sel[23:22]`) is 2'b10 (positive reference) and all other fields are 2'b01 (negative reference).
- R5: Period k (5..15) tests bit 15-k, MSB downward. During that period the field of the bit under test is 2'b10, lower fields are 2'b01, and each already tested bit shows 2'b10 if the comparator was 1 at the end of its period, else 2'b01.
- R6: On the edge ending period 15, the result register loads all 12 decided bits, so the result equals the largest code not above the input level. The register holds its value at every other time.
- R7: `ready` rises on the edge ending period 15 and falls on the edge that begins the next conversion.
- R8: `start_n` is ignored during periods 1..15; a start pulse inside a conversion does not begin another one.
- R9: With `start_n` held low, conversions repeat every 16 clocks: one idle period after each completion.
- R10: `oe_hi_n`=0 drives result bits 11..4 onto `dout`, and `oe_lo_n`=0 drives bits 3..0. A group whose enable is 1 is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start request, active low, honoured only in idle |
| cmp_hi | input | 1 | Comparator result, 1 when the input is at or above the trial level |
| cap_sel | output | 24 | Two bits per capacitor (bit i at [2i+1:2i]): 00 input, 01 negative reference, 10 positive reference |
| track | output | 1 | Array connected to the input |
| balance | output | 1 | Comparator auto-balance |
| ready | output | 1 | Data-ready flag |
| oe_hi_n | input | 1 | Active-low enable for result bits 11..4 |
| oe_lo_n | input | 1 | Active-low enable for result bits 3..0 |
| dout | output | 12 | Three-state result bus |

## Verification
Stimulus changes on the falling edge, and every check samples on a later falling edge. If `start_n` is low before the edge that leaves idle, the following happen:
- `ready` is low one rising edge later;
- the capacitor fields of period k are visible after k rising edges;
- the result and `ready` are due exactly 16 rising edges after the start was applied.

The bench counts rising edges explicitly and samples only at those points. A behavioural comparator, computed from the positive-reference fields it sees, closes the loop. An exhaustive sweep of all 4096 input codes runs back-to-back conversions at the 16-clock cadence.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      SEL_VIN  = 2'b00,
      SEL_REFN = 2'b01,
      SEL_REFP = 2'b10
   } cap_sel_e;

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
   parameter int NBITS     = 12,
   parameter int TRACK_CYC = 3
) (
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic                                     start_n,
   output logic [$clog2(TRACK_CYC+NBITS+1)-1:0]     per_q,
   output logic                                     in_track,
   output logic                                     load_msb,
   output logic                                     testing,
   output logic [$clog2(NBITS)-1:0]                 test_idx,
   output logic                                     conv_begin,
   output logic                                     conv_end
);

   localparam int LAST = TRACK_CYC + NBITS;
   localparam int PW   = $clog2(LAST + 1);
   localparam int IW   = $clog2(NBITS);
   localparam logic [PW-1:0] LAST_P  = PW'(LAST);
   localparam logic [PW-1:0] TRACK_P = PW'(TRACK_CYC);
   localparam logic [PW-1:0] ONE_P   = PW'(1);

   logic [PW-1:0] per_d;

   always_comb begin
      conv_begin = (per_q == '0) && !start_n;
      conv_end   = (per_q == LAST_P);
      in_track   = (per_q <= TRACK_P);
      load_msb   = (per_q == TRACK_P);
      testing    = (per_q > TRACK_P);
      test_idx   = IW'(LAST_P - per_q);
   end

   always_comb begin
      if (per_q == '0)
         per_d = conv_begin ? ONE_P : '0;
      else if (conv_end)
         per_d = '0;
      else
         per_d = per_q + ONE_P;
   end

   always_ff @(posedge clk) begin
      if (rst) per_q <= '0;
      else     per_q <= per_d;
   end

   // A conversion in progress never restarts at period 1 (R8)
   p_no_restart_r8 : assert property (@(posedge clk) disable iff (rst)
      (per_q != '0) |=> (per_q != ONE_P));

endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg
   import sar_seq_pkg::*;
#(
   parameter int NBITS = 12
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_track,
   input  logic                       load_msb,
   input  logic                       testing,
   input  logic [$clog2(NBITS)-1:0]   test_idx,
   input  logic                       cmp_hi,
   output logic [NBITS-1:0]           trial_q,
   output logic [2*NBITS-1:0]         cap_sel
);

   localparam int IW = $clog2(NBITS);

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      logic bit_q;
      logic hit_self;
      logic hit_above;

      assign hit_self = testing && (test_idx == IW'(i));

      if (i < NBITS - 1) begin : g_next
         assign hit_above = testing && (test_idx == IW'(i + 1));
      end else begin : g_top
         assign hit_above = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (rst)            bit_q <= 1'b0;
         else if (load_msb)  bit_q <= (i == NBITS - 1);
         else if (hit_self)  bit_q <= cmp_hi;
         else if (hit_above) bit_q <= 1'b1;
      end

      assign trial_q[i] = bit_q;
      assign cap_sel[2*i +: 2] = in_track ? SEL_VIN : (bit_q ? SEL_REFP : SEL_REFN);
   end

   // The bit under test always carries a trial 1 on the positive reference (R5)
   p_trial_bit_set_r5 : assert property (@(posedge clk) disable iff (rst)
      testing |-> trial_q[test_idx]);

   // Entering the first test period leaves only the MSB trial set (R4)
   p_msb_only_r4 : assert property (@(posedge clk) disable iff (rst)
      $past(load_msb) |-> (trial_q == {1'b1, {(NBITS-1){1'b0}}}));

endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out #(
   parameter int NBITS = 12,
   parameter int SPLIT = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              conv_begin,
   input  logic              conv_end,
   input  logic [NBITS-1:0]  trial_q,
   input  logic              cmp_hi,
   input  logic              oe_hi_n,
   input  logic              oe_lo_n,
   output logic              ready,
   output wire  [NBITS-1:0]  dout
);

   logic [NBITS-1:0] res_q;

   always_ff @(posedge clk) begin
      if (rst)           res_q <= '0;
      else if (conv_end) res_q <= {trial_q[NBITS-1:1], cmp_hi};
   end

   always_ff @(posedge clk) begin
      if (rst)             ready <= 1'b0;
      else if (conv_end)   ready <= 1'b1;
      else if (conv_begin) ready <= 1'b0;
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_drv
      if (i >= SPLIT) begin : g_hi
         assign dout[i] = oe_hi_n ? 1'bz : res_q[i];
      end else begin : g_lo
         assign dout[i] = oe_lo_n ? 1'bz : res_q[i];
      end
   end

   // Result register only changes on a conversion end (R6)
   p_result_hold_r6 : assert property (@(posedge clk) disable iff (rst)
      !conv_end |=> $stable(res_q));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int NBITS     = 12,
   parameter int TRACK_CYC = 3,
   parameter int SPLIT     = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_n,
   input  logic               cmp_hi,
   output logic [2*NBITS-1:0] cap_sel,
   output logic               track,
   output logic               balance,
   output logic               ready,
   input  logic               oe_hi_n,
   input  logic               oe_lo_n,
   output wire  [NBITS-1:0]   dout
);

   localparam int LAST = TRACK_CYC + NBITS;
   localparam int PW   = $clog2(LAST + 1);
   localparam int IW   = $clog2(NBITS);

   if (NBITS < 2) begin : g_bad_nbits
      $error("sar_seq_ctrl: NBITS must be at least 2");
   end
   if (TRACK_CYC < 1) begin : g_bad_track
      $error("sar_seq_ctrl: TRACK_CYC must be at least 1");
   end
   if (SPLIT < 1 || SPLIT >= NBITS) begin : g_bad_split
      $error("sar_seq_ctrl: SPLIT must lie inside the result width");
   end

   logic [PW-1:0]    per_q;
   logic             in_track;
   logic             load_msb;
   logic             testing;
   logic [IW-1:0]    test_idx;
   logic             conv_begin;
   logic             conv_end;
   logic [NBITS-1:0] trial_q;

   sar_seq_timer #(.NBITS(NBITS), .TRACK_CYC(TRACK_CYC)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .start_n    (start_n),
      .per_q      (per_q),
      .in_track   (in_track),
      .load_msb   (load_msb),
      .testing    (testing),
      .test_idx   (test_idx),
      .conv_begin (conv_begin),
      .conv_end   (conv_end)
   );

   sar_seq_reg #(.NBITS(NBITS)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .in_track (in_track),
      .load_msb (load_msb),
      .testing  (testing),
      .test_idx (test_idx),
      .cmp_hi   (cmp_hi),
      .trial_q  (trial_q),
      .cap_sel  (cap_sel)
   );

   sar_seq_out #(.NBITS(NBITS), .SPLIT(SPLIT)) u_out (
      .clk        (clk),
      .rst        (rst),
      .conv_begin (conv_begin),
      .conv_end   (conv_end),
      .trial_q    (trial_q),
      .cmp_hi     (cmp_hi),
      .oe_hi_n    (oe_hi_n),
      .oe_lo_n    (oe_lo_n),
      .ready      (ready),
      .dout       (dout)
   );

   assign track   = in_track;
   assign balance = in_track;

   // Ready rises only after the last test period (R7)
   p_ready_rise_r7 : assert property (@(posedge clk) disable iff (rst)
      $rose(ready) |-> ($past(per_q) == PW'(LAST)));

   // Ready falls exactly as a new conversion enters period 1 (R7)
   p_ready_fall_r7 : assert property (@(posedge clk) disable iff (rst)
      $fell(ready) |-> (per_q == PW'(1)));

endmodule

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int N = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_n = 1'b1;
   logic          cmp_hi;
   logic          oe_hi_n = 1'b0;
   logic          oe_lo_n = 1'b0;
   logic [2*N-1:0] cap_sel;
   logic          track;
   logic          balance;
   logic          ready;
   wire  [N-1:0]  dout;
   logic [N-1:0]  vin = '0;
   logic [N-1:0]  level;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_seq_ctrl i_sar_seq_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start_n (start_n),
      .cmp_hi  (cmp_hi),
      .cap_sel (cap_sel),
      .track   (track),
      .balance (balance),
      .ready   (ready),
      .oe_hi_n (oe_hi_n),
      .oe_lo_n (oe_lo_n),
      .dout    (dout)
   );

   // Behavioural comparator: trial level is the set of positive-reference fields
   always_comb begin
      for (int i = 0; i < N; i++) level[i] = (cap_sel[2*i +: 2] == 2'b10);
      cmp_hi = (vin >= level);
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2*N-1:0] exp_sel(input int k, input logic [N-1:0] v);
      logic [2*N-1:0] s;
      int b;
      s = '0;
      if (k >= 4) begin
         b = 15 - k;
         for (int j = 0; j < N; j++) begin
            if (j > b)       s[2*j +: 2] = v[j] ? 2'b10 : 2'b01;
            else if (j == b) s[2*j +: 2] = 2'b10;
            else             s[2*j +: 2] = 2'b01;
         end
      end
      return s;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [N-1:0] v1;
      logic [N-1:0] v2;
      v1 = 12'hA5C;
      v2 = 12'h3F1;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ready", 64'(ready), 64'(0));
      chk("R1 dout", 64'(dout), 64'(0));
      chk("R1 track", 64'(track), 64'(1));
      chk("R1 balance", 64'(balance), 64'(1));
      chk("R1 cap_sel", 64'(cap_sel), 64'(0));
      rst = 1'b0;

      // R2: idle holds tracking
      for (int c = 0; c < 5; c++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R2 track", 64'(track), 64'(1));
         chk("R2 balance", 64'(balance), 64'(1));
         chk("R2 cap_sel", 64'(cap_sel), 64'(0));
      end

      // Detailed walk through one conversion (R3, R4, R5, R6, R8)
      vin = v1;
      start_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      for (int k = 1; k <= 15; k++) begin
         chk("R3/R4/R5 cap_sel", 64'(cap_sel), 64'(exp_sel(k, v1)));
         chk("R3/R4 track", 64'(track), 64'(k <= 3));
         chk("R3/R4 balance", 64'(balance), 64'(k <= 3));
         chk("R6 result held", 64'(dout), 64'(0));
         chk("R7 ready low", 64'(ready), 64'(0));
         start_n = (k == 7) ? 1'b0 : 1'b1;   // R8: mid-conversion pulse
         @(posedge clk);
         @(negedge clk);
      end
      chk("R6 result", 64'(dout), 64'(v1));
      chk("R7 ready rise", 64'(ready), 64'(1));
      chk("R3 back to track", 64'(cap_sel), 64'(0));

      // R8: the pulse inside the conversion did not start another one
      for (int c = 0; c < 4; c++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R8 ready kept", 64'(ready), 64'(1));
         chk("R8 still idle", 64'(track), 64'(1));
         chk("R8 result kept", 64'(dout), 64'(v1));
      end

      // R7: ready falls when the next conversion begins
      vin = v2;
      start_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start_n = 1'b1;
      chk("R7 ready fall", 64'(ready), 64'(0));
      repeat (15) @(posedge clk);
      @(negedge clk);
      chk("R6 result second", 64'(dout), 64'(v2));
      chk("R7 ready second", 64'(ready), 64'(1));

      // R10: group enables
      oe_hi_n = 1'b1;
      #1;
      for (int i = 4; i < N; i++) chk("R10 upper z", 64'(dout[i] === 1'bz), 64'(1));
      chk("R10 lower driven", 64'(dout[3:0]), 64'(v2[3:0]));
      oe_hi_n = 1'b0;
      oe_lo_n = 1'b1;
      #1;
      for (int i = 0; i < 4; i++) chk("R10 lower z", 64'(dout[i] === 1'bz), 64'(1));
      chk("R10 upper driven", 64'(dout[11:4]), 64'(v2[11:4]));
      oe_lo_n = 1'b0;
      #1;
      chk("R10 both driven", 64'(dout), 64'(v2));

      // R6/R9: exhaustive sweep with start held low, 16-clock cadence
      @(negedge clk);
      start_n = 1'b0;
      for (int v = 0; v < (1 << N); v++) begin
         vin = N'(v);
         @(posedge clk);
         @(negedge clk);
         chk("R7 ready fall sweep", 64'(ready), 64'(0));
         repeat (15) @(posedge clk);
         @(negedge clk);
         chk("R9 ready cadence", 64'(ready), 64'(1));
         chk("R6 sweep result", 64'(dout), 64'(v));
      end
      start_n = 1'b1;

      finish_run();
   end

endmodule